// File: doc/BRIEF.md
# Interrupt Coalescing Unit for a DMA Channel

This block cuts the interrupt rate of a DMA channel by grouping descriptor completions. The descriptor engine sends it a one-cycle pulse for every finished descriptor. The block counts these pulses down from a programmed threshold. When the count runs out, it signals a completion interrupt and starts again from the threshold.

Alongside the count, an inactivity timer is armed on every completion with a programmed timeout. The timeout is measured in ticks that a prescaler derives from the system clock. If no further completion arrives before the timer runs out, the block signals a delay interrupt. It also reloads the count, so that a trickle of traffic still produces interrupts.

Both interrupt outputs are one-cycle set pulses. The register block holds, clears and masks the flags. The live count and the live timer value are driven out for read-back, and a start request reloads the count when the channel is started.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `ioc_set`, `dly_set`, `count_rd` and `timer_rd` are all zero.
- R2: `ctrl_upper` carries control-register bits 31:16. Its bits [7:0] (control bits 23:16) are the threshold and its bits [15:8] (control bits 31:24) are the delay. No other bits take part.
- R3: A `chan_start` pulse loads the count with the threshold, visible on `count_rd` one cycle later. It takes precedence over a completion in the same cycle, which then neither decrements the count nor raises `ioc_set`.
- R4: Each completion without a start decrements the count by one, visible on `count_rd` one cycle later. A count of zero wraps to all ones.
- R5: A completion that finds the count at one raises `ioc_set` for exactly one cycle, starting one cycle later, and reloads the count with the threshold.
- R6: A completion with a nonzero delay loads the timer with the delay, visible on `timer_rd` one cycle later. A nonzero timer then drops by one on each tick.
- R7: A completion with a zero delay does not reload the timer. An idle timer stays at zero and no delay interrupt follows.
- R8: A tick that finds the timer at one, with no reloading completion in that cycle, raises `dly_set` for one cycle. In the same edge it leaves the timer at zero and reloads the count with the threshold.
- R9: When a completion with a nonzero delay coincides with the tick that would expire the timer, the completion wins. No `dly_set` is raised and the timer reloads with the delay.
- R10: One tick occurs every CLK_HZ/TICK_HZ clock cycles. The first tick falls on that many rising edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_upper | input | 16 | Control-register bits 31:16: delay in [15:8], threshold in [7:0] |
| chan_start | input | 1 | One-cycle request to reload the count when the channel starts |
| done_pulse | input | 1 | One-cycle pulse per finished descriptor |
| ioc_set | output | 1 | One-cycle pulse that sets the completion interrupt flag |
| dly_set | output | 1 | One-cycle pulse that sets the delay interrupt flag |
| count_rd | output | 8 | Live completion count, for read-back |
| timer_rd | output | 8 | Live delay timer value, for read-back |

## Verification
The bench builds the block with CLK_HZ=100 and TICK_HZ=25, which gives one tick every four clock cycles. With ticks that short, a full timeout, the spacing between ticks and a completion that lands exactly on the expiring tick can all be reached within a few dozen cycles. A cycle model of the requirements runs next to the block and predicts all four outputs every cycle. Directed sequences cover the count wrap from zero, a start colliding with a completion, and a zero delay.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int FIELD_W   = 8;
    localparam int CFG_W     = 2 * FIELD_W;
    localparam int THR_LSB   = 0;
    localparam int DLY_LSB   = FIELD_W;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        field_t delay;
        field_t thresh;
    } coal_cfg_t;

    function automatic coal_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
        coal_cfg_t c;
        c.thresh = raw[THR_LSB +: FIELD_W];
        c.delay  = raw[DLY_LSB +: FIELD_W];
        return c;
    endfunction

    function automatic int tick_div(input int clk_hz, input int tick_hz);
        int d;
        d = (tick_hz > 0) ? clk_hz / tick_hz : 1;
        return (d < 1) ? 1 : d;
    endfunction

endpackage

// File: rtl/coal_prescale.sv
module coal_prescale #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pre_q <= '0;
                end else if (tick) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + PW'(1);
                end
            end

            assign tick = (pre_q == PW'(DIV - 1));

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R10
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/coal_count.sv
module coal_count
    import coal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   cmpl,
    input  logic   expire,
    input  field_t thresh,
    output field_t cnt_q,
    output logic   ioc_hit
);
    logic hit_now;
    logic reload;

    assign hit_now = cmpl && !start && (cnt_q == field_t'(1));
    assign reload  = start || expire || hit_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ioc_hit <= 1'b0;
        end else begin
            ioc_hit <= hit_now;
            if (reload) begin
                cnt_q <= thresh;
            end else if (cmpl) begin
                cnt_q <= cnt_q - field_t'(1);
            end
        end
    end

    AST_IOC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        ioc_hit |-> (cnt_q == $past(thresh))); // R5

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(start)) |-> (cnt_q == $past(thresh) && !ioc_hit)); // R3

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmpl && !start && !expire && cnt_q != field_t'(1)))
        |-> (cnt_q == $past(cnt_q) - field_t'(1))); // R4

endmodule

// File: rtl/coal_delay.sv
module coal_delay
    import coal_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   cmpl,
    input  field_t dly,
    output field_t tmr_q,
    output logic   expire,
    output logic   dly_hit
);
    logic load;

    assign load   = cmpl && (dly != '0);
    assign expire = tick && (tmr_q == field_t'(1)) && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q   <= '0;
            dly_hit <= 1'b0;
        end else begin
            dly_hit <= expire;
            if (load) begin
                tmr_q <= dly;
            end else if (tick && tmr_q != '0) begin
                tmr_q <= tmr_q - field_t'(1);
            end
        end
    end

    AST_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (rst)
        dly_hit |-> (tmr_q == '0)); // R8

    AST_CMPL_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmpl && dly != '0)) |-> (!dly_hit && tmr_q == $past(dly))); // R9

    AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmpl && dly == '0 && tmr_q == '0)) |-> (tmr_q == '0)); // R7

endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
    import coal_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 50_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] ctrl_upper,
    input  logic             chan_start,
    input  logic             done_pulse,
    output logic             ioc_set,
    output logic             dly_set,
    output logic [FIELD_W-1:0] count_rd,
    output logic [FIELD_W-1:0] timer_rd
);
    localparam int DIV = tick_div(CLK_HZ, TICK_HZ);

    coal_cfg_t cfg;
    logic      tick;
    logic      expire;

    assign cfg = decode_cfg(ctrl_upper);

    coal_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    coal_delay u_dly (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cmpl    (done_pulse),
        .dly     (cfg.delay),
        .tmr_q   (timer_rd),
        .expire  (expire),
        .dly_hit (dly_set)
    );

    coal_count u_cnt (
        .clk     (clk),
        .rst     (rst),
        .start   (chan_start),
        .cmpl    (done_pulse),
        .expire  (expire),
        .thresh  (cfg.thresh),
        .cnt_q   (count_rd),
        .ioc_hit (ioc_set)
    );

    AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (rst)
        dly_set |-> (count_rd == $past(cfg.thresh))); // R8

    AST_PULSES_RESET: assert property (@(posedge clk)
        $past(rst) |-> (!ioc_set && !dly_set && count_rd == '0 && timer_rd == '0)); // R1

endmodule

// File: tb/sim_irq_coalesce.sv
module sim_irq_coalesce;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl_upper = '0;
    logic        chan_start = 1'b0;
    logic        done_pulse = 1'b0;
    logic        ioc_set, dly_set;
    logic [7:0]  count_rd, timer_rd;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    irq_coalesce #(.CLK_HZ(100), .TICK_HZ(25)) u0 (
        .clk(clk), .rst(rst), .ctrl_upper(ctrl_upper), .chan_start(chan_start),
        .done_pulse(done_pulse), .ioc_set(ioc_set), .dly_set(dly_set),
        .count_rd(count_rd), .timer_rd(timer_rd)
    );

    typedef struct {
        logic       ioc;
        logic       dly;
        logic [7:0] cnt;
        logic [7:0] tmr;
    } exp_t;

    exp_t exp_q[$];

    // Reference model of the requirements, one step per rising edge
    int         mpre = 0;
    logic [7:0] mcnt = 0, mtmr = 0;
    always @(posedge clk) begin
        exp_t e;
        logic tk, ld, ex, hit;
        logic [7:0] thr, dl;
        if (rst) begin
            mpre = 0; mcnt = 0; mtmr = 0;
            e.ioc = 0; e.dly = 0;
        end else begin
            thr = ctrl_upper[7:0];
            dl  = ctrl_upper[15:8];
            tk  = (mpre == DIV - 1);
            ld  = done_pulse && (dl != 0);
            ex  = tk && (mtmr == 8'd1) && !ld;
            hit = done_pulse && !chan_start && (mcnt == 8'd1);
            if (chan_start || ex || hit) mcnt = thr;
            else if (done_pulse) mcnt = mcnt - 8'd1;
            if (ld) mtmr = dl;
            else if (tk && mtmr != 0) mtmr = mtmr - 8'd1;
            mpre = tk ? 0 : mpre + 1;
            e.ioc = hit; e.dly = ex;
        end
        e.cnt = mcnt; e.tmr = mtmr;
        exp_q.push_back(e);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: compares every cycle against the model queue
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0 && !ended) begin
            e = exp_q.pop_front();
            chk(count_rd == e.cnt, "R4 count", count_rd, e.cnt);
            chk(timer_rd == e.tmr, "R6 timer", timer_rd, e.tmr);
            chk(ioc_set == e.ioc, "R5 ioc", ioc_set, e.ioc);
            chk(dly_set == e.dly, "R8 dly", dly_set, e.dly);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_done();
        done_pulse = 1'b1; @(negedge clk); done_pulse = 1'b0;
    endtask

    task automatic pulse_start();
        chan_start = 1'b1; @(negedge clk); chan_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        int seen, gap, prev;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk(count_rd == 0 && timer_rd == 0 && !ioc_set && !dly_set, "R1 reset", count_rd, 0);

        // R4 wrap from zero, R7 zero delay leaves timer idle
        pulse_done();
        chk(count_rd == 8'hFF, "R4 wrap", count_rd, 255);
        cyc(3 * DIV);
        chk(timer_rd == 0 && !dly_set, "R7 idle", timer_rd, 0);

        // R2 / R3 start loads threshold from bits [7:0]
        ctrl_upper = {8'd0, 8'd3};
        pulse_start();
        chk(count_rd == 3, "R3 start load", count_rd, 3);

        // R3 start beats simultaneous completion
        chan_start = 1'b1; done_pulse = 1'b1; @(negedge clk);
        chan_start = 1'b0; done_pulse = 1'b0;
        chk(count_rd == 3 && !ioc_set, "R3 start wins", count_rd, 3);

        // R4 decrements
        pulse_done();
        chk(count_rd == 2, "R4 dec", count_rd, 2);
        pulse_done();
        chk(count_rd == 1, "R4 dec", count_rd, 1);

        // R5 ioc pulse and reload
        pulse_done();
        chk(ioc_set == 1, "R5 ioc set", ioc_set, 1);
        chk(count_rd == 3, "R5 reload", count_rd, 3);
        cyc(1);
        chk(ioc_set == 0, "R5 one cycle", ioc_set, 0);

        // R2 delay from bits [15:8]; R6 timer load
        ctrl_upper = {8'd6, 8'd10};
        pulse_start();
        pulse_done();
        chk(timer_rd == 6, "R6 load", timer_rd, 6);

        // R10 tick spacing
        prev = timer_rd;
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (timer_rd != prev) seen = 1;
        end
        prev = timer_rd;
        gap = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            gap++;
            if (timer_rd != prev) break;
        end
        chk(gap == DIV, "R10 tick gap", gap, DIV);
        chk(timer_rd == prev - 1, "R6 step", timer_rd, prev - 1);

        // R8 expiry: pulse, timer zero, count reload (was 9)
        seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (dly_set) seen = 1;
        end
        chk(seen == 1, "R8 expire", seen, 1);
        chk(count_rd == 10 && timer_rd == 0, "R8 reload", count_rd, 10);
        cyc(1);
        chk(dly_set == 0, "R8 one cycle", dly_set, 0);

        // R9 completion on the expiring tick wins
        ctrl_upper = {8'd3, 8'd10};
        pulse_done();
        seen = 0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (timer_rd == 1 && mpre == DIV - 1) seen = 1;
            else @(negedge clk);
        end
        chk(seen == 1, "R9 reach", seen, 1);
        pulse_done();
        chk(!dly_set && timer_rd == 3, "R9 cmpl wins", timer_rd, 3);

        // R7 zero delay with idle timer after expiry
        cyc(20);
        ctrl_upper = {8'd0, 8'd10};
        pulse_done();
        cyc(3 * DIV);
        chk(timer_rd == 0 && !dly_set, "R7 no arm", timer_rd, 0);

        cyc(2);
        finish_run();
    end

endmodule